// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host and one asynchronous EDO DRAM device with 2M byte-wide locations. For each accepted request it produces one complete multiplexed-address memory cycle. The row part of the word address goes onto the shared address pins and the row strobe falls. The column part then follows and the column strobe falls, with write enable or output enable qualifying the access. For a read, the returned byte is captured and handed back to the host with a one-cycle valid pulse. Every analog timing minimum is expressed as a parameter counted in system clocks.

The host uses a level request held until a one-cycle acknowledge. A separate refresh scheduler owns all refresh activity. This block only grants it the strobes while nothing else is in progress and the precharge minimums are met, and it takes them back when the scheduler reports completion. Host accesses are refused until the scheduler reports that the power-up initialisation has finished.

Top module: `edo_seq`

## Requirements
- R1: `dram_addr` carries the row part (`addr[10:0]`) from the cycle after acceptance until the column strobe falls. From that point until the row strobe rises it carries the column part (`{1'b0, addr[20:11]}`), held stable. At all other times it is zero.
- R2: `ack` is a one-cycle pulse in the cycle after the request is sampled, with the row strobe still high. `dram_cas_n` goes low after exactly T_RCD cycles of row strobe low and stays low for exactly T_CAS cycles. After reset, all strobes are high and `ack`, `rdata_valid` and `refresh_grant` are low.
- R3: `dram_ras_n` stays low for exactly max(T_RAS, T_RCD+T_CAS+1) cycles. The column strobe is never low while the row strobe is high, so the column strobe rises first.
- R4: A request or refresh is taken up only in a cycle in which the row strobe has been high for at least T_RP cycles and the column strobe for at least T_CP cycles, counting that cycle. This keeps the row strobe high for at least T_RP+1 cycles between two cycles, including a request held high for back-to-back accesses.
- R5: In a write (`rw`=1), `dram_we_n` is low in exactly the column-strobe-low cycles. `dram_dq_oe`=1 and `dram_dq_out`=wdata in those same cycles, and `dram_oe_n` stays high.
- R6: In a read (`rw`=0), `dram_oe_n` is low in exactly the column-strobe-low cycles and `dram_we_n` stays high. `dram_dq_in` is sampled at the end of the last of those cycles and appears on `rdata` with a one-cycle `rdata_valid` pulse in the next cycle.
- R7: `dram_dq_oe` is never high outside the column-strobe-low cycles of a write.
- R8: When precharge is met in idle, `refresh_req` has priority over `req`. `refresh_grant` rises in the next cycle and stays high until `refresh_done` is sampled, and the block's strobes stay high throughout.
- R9: No host request is acknowledged until `init_done` has been sampled high at least once. Refresh may be granted before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| init_done | input | 1 | Scheduler reports power-up sequence complete |
| req | input | 1 | Host access request, held until ack |
| rw | input | 1 | 1 = write, 0 = read |
| addr | input | 21 | Word address |
| wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle acceptance pulse |
| rdata_valid | output | 1 | One-cycle read data strobe |
| rdata | output | 8 | Read byte |
| refresh_req | input | 1 | Scheduler asks for the strobes |
| refresh_done | input | 1 | Scheduler returns the strobes |
| refresh_grant | output | 1 | Strobes handed to the scheduler |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward the device |
| dram_dq_oe | output | 1 | Data pad drive enable |
| dram_dq_in | input | 8 | Data from the device |

## Verification
The bench builds the block with T_RCD=2, T_CAS=2, T_RAS=7, T_RP=3 and T_CP=7. With T_RAS above T_RCD+T_CAS+1, the row strobe is stretched past the column phase, so the active-window extension is exercised. With T_CP large, the column precharge, not the row precharge, decides when a held request is taken up again, so the second precharge condition is actually tested. Reads return bytes from a pin-level device model keyed by latched row and column, which checks the address split end to end, including the all-ones address.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASET = 3'd1,
    ST_RACT = 3'd2,
    ST_CACT = 3'd3,
    ST_HOLD = 3'd4,
    ST_REF  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    AS_NONE = 2'd0,
    AS_ROW  = 2'd1,
    AS_COL  = 2'd2
  } addr_sel_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_strobe_timer.sv
module edo_strobe_timer #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic met
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(LIMIT);
  localparam logic [CNT_W:0]   LIM_X = (CNT_W+1)'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (!level)
      cnt_d = '0;
    else if (cnt_q != CAP)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // level held this cycle and, with this cycle counted, long enough
  assign met = level && (({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= LIM_X);

endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux
  import edo_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned ROW_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  addr_sel_e         sel,
  output logic [ROW_W-1:0]  bus
);
  localparam int unsigned COL_W = ADDR_W - ROW_W;

  logic [ROW_W-1:0] row_part;
  logic [ROW_W-1:0] col_part;

  assign row_part = addr[ROW_W-1:0];

  generate
    if (COL_W < ROW_W) begin : g_pad
      assign col_part = {{(ROW_W-COL_W){1'b0}}, addr[ADDR_W-1:ROW_W]};
    end else begin : g_full
      assign col_part = addr[ADDR_W-1:ROW_W];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      AS_ROW:  bus = row_part;
      AS_COL:  bus = col_part;
      default: bus = '0;
    endcase
  end

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RAS  = 6,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_CP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              req,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata,
  input  logic              refresh_req,
  input  logic              refresh_done,
  output logic              refresh_grant,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int unsigned PH_MAX   = max2(T_RCD, T_CAS);
  localparam int unsigned PH_W     = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] RCD_LAST = PH_W'(T_RCD - 1);
  localparam logic [PH_W-1:0] CAS_LAST = PH_W'(T_CAS - 1);

  seq_state_e        state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              accept, sample_rd;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              init_q;
  logic              ack_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  logic      ras_low, cas_low;
  logic      ras_act_met, ras_pre_met, cas_pre_met, pre_ok;
  addr_sel_e asel;

  // strobe decode from registered state
  always_comb begin
    ras_low = (state_q == ST_RACT) || (state_q == ST_CACT) || (state_q == ST_HOLD);
    cas_low = (state_q == ST_CACT);
    unique case (state_q)
      ST_ASET, ST_RACT: asel = AS_ROW;
      ST_CACT, ST_HOLD: asel = AS_COL;
      default:          asel = AS_NONE;
    endcase
  end

  edo_strobe_timer #(.LIMIT(T_RAS)) u_ras_act (
    .clk(clk), .rst_n(rst_n), .level(ras_low), .met(ras_act_met)
  );
  edo_strobe_timer #(.LIMIT(T_RP)) u_ras_pre (
    .clk(clk), .rst_n(rst_n), .level(!ras_low), .met(ras_pre_met)
  );
  edo_strobe_timer #(.LIMIT(T_CP)) u_cas_pre (
    .clk(clk), .rst_n(rst_n), .level(!cas_low), .met(cas_pre_met)
  );

  assign pre_ok = ras_pre_met && cas_pre_met;

  edo_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_amux (
    .addr(addr_q), .sel(asel), .bus(dram_addr)
  );

  // next state
  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    accept    = 1'b0;
    sample_rd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pre_ok) begin
          if (refresh_req) begin
            state_d = ST_REF;
          end else if (init_q && req) begin
            accept  = 1'b1;
            state_d = ST_ASET;
          end
        end
      end
      ST_ASET: begin
        state_d = ST_RACT;
        ph_d    = '0;
      end
      ST_RACT: begin
        if (ph_q == RCD_LAST) begin
          state_d = ST_CACT;
          ph_d    = '0;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_CACT: begin
        if (ph_q == CAS_LAST) begin
          state_d   = ST_HOLD;
          ph_d      = '0;
          sample_rd = !wr_q;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (ras_act_met) state_d = ST_IDLE;
      end
      ST_REF: begin
        if (refresh_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= rw;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      init_q <= 1'b0;
    else if (init_done && !init_q)
      init_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      ack_q    <= accept;
      rvalid_q <= sample_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (sample_rd)
      rdata_q <= dram_dq_in;
  end

  assign ack           = ack_q;
  assign rdata_valid   = rvalid_q;
  assign rdata         = rdata_q;
  assign refresh_grant = (state_q == ST_REF);
  assign dram_ras_n    = !ras_low;
  assign dram_cas_n    = !cas_low;
  assign dram_we_n     = !(cas_low && wr_q);
  assign dram_oe_n     = !(cas_low && !wr_q);
  assign dram_dq_oe    = cas_low && wr_q;
  assign dram_dq_out   = wdata_q;

endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic             ack,
  input logic             rdata_valid,
  input logic             refresh_grant,
  input logic [ROW_W-1:0] dram_addr,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic             dram_dq_oe
);
  logic [15:0] lo_cnt, hi_cnt;
  logic        init_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      init_seen <= 1'b0;
    end else begin
      lo_cnt <= dram_ras_n ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
      hi_cnt <= !dram_ras_n ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
      if (init_done) init_seen <= 1'b1;
    end
  end

  AST_ROW_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(dram_ras_n) |-> $stable(dram_addr)); // R1
  AST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr)); // R1
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R2
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n) !dram_cas_n |-> !dram_ras_n); // R3
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(dram_ras_n) |-> (lo_cnt >= 16'(T_RAS))); // R3
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(dram_ras_n) |-> (hi_cnt >= 16'(T_RP))); // R4
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n) !dram_we_n |-> (!dram_cas_n && dram_oe_n)); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rdata_valid |=> !rdata_valid); // R6
  AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) dram_dq_oe |-> (!dram_we_n && !dram_cas_n)); // R7
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) refresh_grant |-> (dram_ras_n && dram_cas_n && !dram_dq_oe)); // R8
  AST_NO_ACK_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n) !init_seen |-> !ack); // R9

endmodule

bind edo_seq edo_seq_chk #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .ack(ack),
  .rdata_valid(rdata_valid), .refresh_grant(refresh_grant),
  .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_seq_tb.sv
module edo_seq_tb;
  localparam int P_RCD = 2;
  localparam int P_CAS = 2;
  localparam int P_RAS = 7;
  localparam int P_RP  = 3;
  localparam int P_CP  = 7;
  localparam int HOLD_N = (P_RAS - P_RCD - P_CAS > 1) ? (P_RAS - P_RCD - P_CAS) : 1;

  logic        clk, rst_n, init_done, req, rw, refresh_req, refresh_done;
  logic [20:0] addr;
  logic [7:0]  wdata, rdata, dram_dq_out, dram_dq_in;
  logic        ack, rdata_valid, refresh_grant;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  int n_checks = 0;
  int n_errors = 0;

  edo_seq #(.T_RCD(P_RCD), .T_CAS(P_CAS), .T_RAS(P_RAS), .T_RP(P_RP), .T_CP(P_CP)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req(req), .rw(rw),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata_valid(rdata_valid), .rdata(rdata),
    .refresh_req(refresh_req), .refresh_done(refresh_done), .refresh_grant(refresh_grant),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // pin-level device model
  logic [7:0]  dmem [int];
  logic [10:0] lat_row, lat_col;
  logic        prev_ras, prev_cas;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; dram_dq_in = 8'h00;
    end else begin
      if (!dram_ras_n && prev_ras) lat_row = dram_addr;
      if (!dram_cas_n && prev_cas) lat_col = dram_addr;
      if (!dram_cas_n && !dram_we_n && dram_dq_oe) dmem[{lat_col, lat_row}] = dram_dq_out;
      if (!dram_cas_n && !dram_oe_n)
        dram_dq_in = dmem.exists({lat_col, lat_row}) ? dmem[{lat_col, lat_row}] : 8'h00;
      else
        dram_dq_in = 8'h00;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end
  end

  // behavioural reference model
  typedef struct packed {
    logic ras, cas, we, oe;
    logic [10:0] a;
    logic dqoe;
    logic [7:0] dq;
    logic ack, rv;
    logic [7:0] rd;
  } vec_t;

  vec_t       expq[$];
  logic [7:0] mmem [int];
  int rh, ch;
  bit mref, minit;

  function automatic vec_t idle_vec();
    vec_t v;
    v = '0;
    v.ras = 1'b1; v.cas = 1'b1; v.we = 1'b1; v.oe = 1'b1;
    return v;
  endfunction

  task automatic plan_access(input bit wr, input logic [20:0] a, input logic [7:0] d);
    vec_t v;
    logic [10:0] row, col;
    logic [7:0] exp_rd;
    row = a[10:0];
    col = {1'b0, a[20:11]};
    exp_rd = mmem.exists(int'(a)) ? mmem[int'(a)] : 8'h00;
    if (wr) mmem[int'(a)] = d;
    v = idle_vec(); v.a = row; v.ack = 1'b1;
    expq.push_back(v);
    for (int i = 0; i < P_RCD; i++) begin
      v = idle_vec(); v.ras = 1'b0; v.a = row; expq.push_back(v);
    end
    for (int i = 0; i < P_CAS; i++) begin
      v = idle_vec(); v.ras = 1'b0; v.cas = 1'b0; v.a = col;
      if (wr) begin v.we = 1'b0; v.dqoe = 1'b1; v.dq = d; end
      else v.oe = 1'b0;
      expq.push_back(v);
    end
    for (int i = 0; i < HOLD_N; i++) begin
      v = idle_vec(); v.ras = 1'b0; v.a = col;
      if (i == 0 && !wr) begin v.rv = 1'b1; v.rd = exp_rd; end
      expq.push_back(v);
    end
  endtask

  always @(negedge clk) begin
    vec_t e;
    bit idle_cyc, eg;
    if (!rst_n) begin
      rh = 0; ch = 0; mref = 0; minit = 0; expq.delete();
    end else begin
      idle_cyc = (expq.size() == 0);
      if (idle_cyc) begin e = idle_vec(); eg = mref; end
      else begin e = expq.pop_front(); eg = 1'b0; end
      chk(dram_ras_n == e.ras, "R3", "ras_n", int'(dram_ras_n), int'(e.ras));
      chk(dram_cas_n == e.cas, "R2", "cas_n", int'(dram_cas_n), int'(e.cas));
      chk(dram_addr == e.a, "R1", "dram_addr", int'(dram_addr), int'(e.a));
      chk(dram_we_n == e.we, "R5", "we_n", int'(dram_we_n), int'(e.we));
      chk(dram_oe_n == e.oe, "R6", "oe_n", int'(dram_oe_n), int'(e.oe));
      chk(dram_dq_oe == e.dqoe, "R7", "dq_oe", int'(dram_dq_oe), int'(e.dqoe));
      if (e.dqoe) chk(dram_dq_out == e.dq, "R5", "dq_out", int'(dram_dq_out), int'(e.dq));
      chk(ack == e.ack, "R2", "ack", int'(ack), int'(e.ack));
      chk(rdata_valid == e.rv, "R6", "rdata_valid", int'(rdata_valid), int'(e.rv));
      if (e.rv) chk(rdata == e.rd, "R6", "rdata", int'(rdata), int'(e.rd));
      chk(refresh_grant == eg, "R8", "refresh_grant", int'(refresh_grant), int'(eg));
      rh = e.ras ? rh + 1 : 0;
      ch = e.cas ? ch + 1 : 0;
      if (idle_cyc) begin
        if (mref) begin
          if (refresh_done) mref = 0;
        end else if (rh >= P_RP && ch >= P_CP) begin
          if (refresh_req) mref = 1;
          else if (minit && req) plan_access(rw, addr, wdata);
        end
      end
      if (init_done) minit = 1;
    end
  end

  // R4 precharge gap measured on pins
  int gap;
  logic gprev;
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; gprev = 1'b1;
    end else begin
      if (!dram_ras_n && gprev)
        chk(gap >= P_RP + 1, "R4", "ras high gap", gap, P_RP + 1);
      gap = dram_ras_n ? gap + 1 : 0;
      gprev = dram_ras_n;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic access(input bit wr, input logic [20:0] a, input logic [7:0] d, input bit keep);
    @(posedge clk); #1;
    req = 1'b1; rw = wr; addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    if (!keep) begin @(posedge clk); #1; req = 1'b0; end
  endtask

  task automatic do_refresh();
    @(posedge clk); #1 refresh_req = 1'b1;
    do @(negedge clk); while (!refresh_grant);
    @(posedge clk); #1 refresh_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 refresh_done = 1'b1;
    @(posedge clk); #1 refresh_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; init_done = 1'b0; req = 1'b0; rw = 1'b0; addr = '0; wdata = '0;
    refresh_req = 1'b0; refresh_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R2", "reset strobes", 0, 1);
    chk(!ack && !rdata_valid && !refresh_grant && !dram_dq_oe, "R2", "reset outputs", 0, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R9 refresh before init, then request held without init
    do_refresh();
    @(posedge clk); #1;
    req = 1'b1; rw = 1'b1; addr = 21'h0000AA; wdata = 8'h5A;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(!ack, "R9", "ack before init", int'(ack), 0);
    end
    @(posedge clk); #1 init_done = 1'b1;
    do @(negedge clk); while (!ack);
    @(posedge clk); #1 req = 1'b0;

    // writes over distinct patterns and corners
    access(1'b1, 21'h000000, 8'h11, 1'b0);
    access(1'b1, 21'h1FFFFF, 8'hEE, 1'b0);
    access(1'b1, 21'h0AB7FF, 8'hC3, 1'b0);
    access(1'b1, 21'h154800, 8'h3C, 1'b0);

    // reads, back to back with req held (R4 held request)
    access(1'b0, 21'h1FFFFF, 8'h00, 1'b1);
    access(1'b0, 21'h000000, 8'h00, 1'b1);
    access(1'b0, 21'h0000AA, 8'h00, 1'b1);
    access(1'b0, 21'h0AB7FF, 8'h00, 1'b1);
    access(1'b0, 21'h154800, 8'h00, 1'b1);
    access(1'b0, 21'h12345, 8'h00, 1'b0);

    // R8 refresh and request together: refresh first
    @(posedge clk); #1;
    req = 1'b1; rw = 1'b1; addr = 21'h0F0F0F; wdata = 8'h99; refresh_req = 1'b1;
    do @(negedge clk); while (!refresh_grant);
    chk(!ack, "R8", "no ack with grant", int'(ack), 0);
    @(posedge clk); #1 refresh_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(refresh_grant && !ack, "R8", "grant held until done", int'(refresh_grant), 1);
    @(posedge clk); #1 refresh_done = 1'b1;
    @(posedge clk); #1 refresh_done = 1'b0;
    do @(negedge clk); while (!ack);
    @(posedge clk); #1 req = 1'b0;
    access(1'b1, 21'h0F0F0F, 8'h77, 1'b1);
    access(1'b0, 21'h0F0F0F, 8'h00, 1'b0);

    repeat (30) @(posedge clk);
    finish_run();
  end

endmodule